// File: doc/BRIEF.md
# Discharge-Time Counter Bank

This block measures, in parallel, how long each column of a compute-in-memory crossbar takes to discharge. One synchronous start pulse clears and launches every channel in the same clock cycle. Each channel then counts system clock cycles until its own comparator input rises. That comparator fires when the column capacitor has fallen to the reference voltage. A larger summed column current discharges the capacitor sooner, so a smaller count means a stronger response.

Every channel holds its captured count and raises a per-channel finished flag. A channel whose counter reaches all ones before its comparator fires saturates there and is marked as timed out. When every channel has finished, the bank raises `done_o`. It also registers the index of the channel with the smallest valid count, which acts as a winner-take-all classification. If every channel timed out, it raises a no-winner flag instead. The comparator inputs are asynchronous, so they are synchronized inside the block.

Top module: `discharge_timer_bank`

## Requirements
- R1: After synchronous reset, every count, every finished flag, every timeout flag, `done_o`, `win_idx_o` and `no_win_o` are zero.
- R2: `start_i` is accepted when the bank is idle or done. In the following cycle all counts read 0, and `done_o`, `win_idx_o` and `no_win_o` read 0. While the bank is running, `start_i` has no effect on any output.
- R3: A channel's captured count equals the number of clock edges after the edge that accepted start, up to and including the edge at which its stop input is first sampled high, plus one. In other words, a stop raised just after the a-th edge following start gives a count of a+2.
- R4: Only the first rising edge of a stop input during a run is used. A stop edge while the bank is idle or done, or a later edge on a channel that has already stopped, leaves that channel's count and flags unchanged.
- R5: A running channel whose count reaches all ones stops there, with its timeout flag set. This happens on the 2^CNT_W-1-th edge after start. If a stop edge is acted on in that same cycle, the stop wins: the count is all ones minus one and there is no timeout.
- R6: Each channel's finished flag is set when it stops or times out. `done_o` rises one cycle after the last channel finishes and stays high until the next accepted start.
- R7: When `done_o` is high, `win_idx_o` is the index of the smallest count among channels that did not time out. If two channels tie, the lower index wins.
- R8: If every channel timed out, `no_win_o` is 1 and `win_idx_o` is 0 while `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launch all channels (synchronous pulse) |
| stop_i | input | NUM_CH | Asynchronous comparator outputs, one per channel |
| count_o | output | NUM_CH*CNT_W | Captured counts, channel i at bits [i*CNT_W +: CNT_W] |
| ch_fin_o | output | NUM_CH | Per-channel finished flag |
| ch_tmo_o | output | NUM_CH | Per-channel timeout flag |
| done_o | output | 1 | All channels finished |
| win_idx_o | output | $clog2(NUM_CH) | Index of the fastest valid channel |
| no_win_o | output | 1 | Every channel timed out |

## Verification
Two of this block's functions can land on the same clock edge: a channel's stop edge being acted on, and that channel's counter saturating. The bench provokes this by raising one stop input exactly CNT_W-dependent cycles after start, so that the synchronized edge arrives in the saturation cycle. A neighbouring channel is raised one cycle later. The first channel must hold all ones minus one with no timeout flag, and the second must hold all ones with a timeout flag. In the same run, `done_o` must rise exactly one cycle after that shared final edge.

// File: rtl/dtb_pkg.sv
package dtb_pkg;

  typedef enum logic [1:0] {
    BANK_IDLE = 2'd0,
    BANK_RUN  = 2'd1,
    BANK_DONE = 2'd2
  } bank_state_e;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/dtb_stop_sync.sv
module dtb_stop_sync #(
  parameter int NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] stop_async_i,
  output logic [NUM_CH-1:0] rise_o
);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        meta_q <= stop_async_i[g];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end

    assign rise_o[g] = sync_q & ~prev_q;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      rise_o[g] |=> !rise_o[g]); // R4
  end

endmodule

// File: rtl/dtb_counter_lane.sv
module dtb_counter_lane #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic             stop_rise_i,
  output logic [CNT_W-1:0] count_o,
  output logic             fin_o,
  output logic             tmo_o
);

  localparam logic [CNT_W-1:0] FULL = '1;
  localparam logic [CNT_W-1:0] LAST = FULL - 1'b1;

  logic [CNT_W-1:0] count_q;
  logic             run_q, fin_q, tmo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      run_q   <= 1'b0;
      fin_q   <= 1'b0;
      tmo_q   <= 1'b0;
    end else if (clear_i) begin
      count_q <= '0;
      run_q   <= 1'b1;
      fin_q   <= 1'b0;
      tmo_q   <= 1'b0;
    end else if (run_q) begin
      if (stop_rise_i) begin
        run_q <= 1'b0;
        fin_q <= 1'b1;
      end else if (count_q == LAST) begin
        count_q <= FULL;
        run_q   <= 1'b0;
        fin_q   <= 1'b1;
        tmo_q   <= 1'b1;
      end else begin
        count_q <= count_q + 1'b1;
      end
    end
  end

  assign count_o = count_q;
  assign fin_o   = fin_q;
  assign tmo_o   = tmo_q;

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> (count_q == '0) && !fin_q && !tmo_q); // R2
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    run_q && !clear_i && !stop_rise_i |=> count_q == $past(count_q) + 1'b1); // R3
  AST_FIN_HOLD: assert property (@(posedge clk) disable iff (rst)
    fin_q && !clear_i |=> $stable(count_q) && fin_q && $stable(tmo_q)); // R4
  AST_TMO_FULL: assert property (@(posedge clk) disable iff (rst)
    tmo_q |-> fin_q && (count_q == FULL)); // R5
  AST_STOP_NO_TMO: assert property (@(posedge clk) disable iff (rst)
    run_q && !clear_i && stop_rise_i |=> fin_q && !tmo_q); // R5

endmodule

// File: rtl/dtb_min_pick.sv
module dtb_min_pick #(
  parameter int NUM_CH = 16,
  parameter int CNT_W  = 16,
  parameter int IDX_W  = 4
) (
  input  logic [NUM_CH*CNT_W-1:0] vals_i,
  input  logic [NUM_CH-1:0]       ok_i,
  output logic [IDX_W-1:0]        idx_o,
  output logic                    any_o
);

  localparam int LVL = (NUM_CH > 1) ? $clog2(NUM_CH) : 0;
  localparam int P   = 1 << LVL;

  logic [CNT_W-1:0] nv  [1:2*P-1];
  logic [IDX_W-1:0] ni  [1:2*P-1];
  logic             nok [1:2*P-1];

  for (genvar j = 0; j < P; j++) begin : g_leaf
    if (j < NUM_CH) begin : g_real
      assign nv[P+j]  = vals_i[j*CNT_W +: CNT_W];
      assign ni[P+j]  = IDX_W'(j);
      assign nok[P+j] = ok_i[j];
    end else begin : g_pad
      assign nv[P+j]  = '0;
      assign ni[P+j]  = '0;
      assign nok[P+j] = 1'b0;
    end
  end

  for (genvar n = 1; n < P; n++) begin : g_node
    logic take_r;
    assign take_r = nok[2*n+1] && (!nok[2*n] || (nv[2*n+1] < nv[2*n]));
    assign nv[n]  = take_r ? nv[2*n+1] : nv[2*n];
    assign ni[n]  = take_r ? ni[2*n+1] : ni[2*n];
    assign nok[n] = nok[2*n] | nok[2*n+1];
  end

  assign idx_o = ni[1];
  assign any_o = nok[1];

endmodule

// File: rtl/discharge_timer_bank.sv
module discharge_timer_bank
  import dtb_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int CNT_W  = 16,
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start_i,
  input  logic [NUM_CH-1:0]       stop_i,
  output logic [NUM_CH*CNT_W-1:0] count_o,
  output logic [NUM_CH-1:0]       ch_fin_o,
  output logic [NUM_CH-1:0]       ch_tmo_o,
  output logic                    done_o,
  output logic [IDX_W-1:0]        win_idx_o,
  output logic                    no_win_o
);

  bank_state_e      state_q;
  logic             start_acc;
  logic [NUM_CH-1:0] rise;
  logic             all_fin;
  logic [IDX_W-1:0] pick_idx;
  logic             pick_any;
  logic             done_q, no_win_q;
  logic [IDX_W-1:0] win_q;

  assign start_acc = start_i && (state_q != BANK_RUN);

  dtb_stop_sync #(.NUM_CH(NUM_CH)) u_sync (
    .clk          (clk),
    .rst          (rst),
    .stop_async_i (stop_i),
    .rise_o       (rise)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    dtb_counter_lane #(.CNT_W(CNT_W)) u_lane (
      .clk         (clk),
      .rst         (rst),
      .clear_i     (start_acc),
      .stop_rise_i (rise[g]),
      .count_o     (count_o[g*CNT_W +: CNT_W]),
      .fin_o       (ch_fin_o[g]),
      .tmo_o       (ch_tmo_o[g])
    );
  end

  assign all_fin = &ch_fin_o;

  dtb_min_pick #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_pick (
    .vals_i (count_o),
    .ok_i   (ch_fin_o & ~ch_tmo_o),
    .idx_o  (pick_idx),
    .any_o  (pick_any)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= BANK_IDLE;
      done_q   <= 1'b0;
      win_q    <= '0;
      no_win_q <= 1'b0;
    end else begin
      case (state_q)
        BANK_RUN: begin
          if (all_fin) begin
            state_q  <= BANK_DONE;
            done_q   <= 1'b1;
            win_q    <= pick_any ? pick_idx : '0;
            no_win_q <= !pick_any;
          end
        end
        default: begin
          if (start_i) begin
            state_q  <= BANK_RUN;
            done_q   <= 1'b0;
            win_q    <= '0;
            no_win_q <= 1'b0;
          end
        end
      endcase
    end
  end

  assign done_o    = done_q;
  assign win_idx_o = win_q;
  assign no_win_o  = no_win_q;

  AST_DONE_ALL_FIN: assert property (@(posedge clk) disable iff (rst)
    done_o |-> &ch_fin_o); // R6
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
    done_o && !start_i |=> done_o); // R6
  AST_RUN_IGNORES_START: assert property (@(posedge clk) disable iff (rst)
    (state_q == BANK_RUN) && !all_fin |=> !done_o); // R2
  AST_WIN_LIVE: assert property (@(posedge clk) disable iff (rst)
    done_o && !no_win_o |-> !ch_tmo_o[win_idx_o]); // R7
  AST_NOWIN_ALL_TMO: assert property (@(posedge clk) disable iff (rst)
    done_o && no_win_o |-> (&ch_tmo_o) && (win_idx_o == '0)); // R8

endmodule

// File: tb/discharge_timer_bank_test.sv
module discharge_timer_bank_test;

  localparam int CLK_PERIOD = 10;
  localparam int NCH  = 16;
  localparam int CW   = 8;
  localparam int IW   = 4;
  localparam int CMAX = (1 << CW) - 1;
  localparam int NVEC = 4;

  // -1 means the stop input never rises in that run
  localparam int VEC_DLY [NVEC][NCH] = '{
    '{20, 21, 22, 23, 24, 25, 26, 27, 28, 29, 30, 31, 32, 33, 34, 35},
    '{45, 42, 39, 36, 33, 30, 27, 24, 21, 18, 15, 12, 9, 6, 3, 1},
    '{30, 30, 30, 30, 30, 7, 30, 30, 30, 7, 30, 30, 30, 30, 30, 30},
    '{-1, -1, -1, -1, 100, 100, 253, 252, 100, 100, 100, 100, 60, 100, 100, 100}
  };
  localparam int VEC_WIN   [NVEC] = '{0, 15, 5, 12};
  localparam int VEC_NOWIN [NVEC] = '{0, 0, 0, 0};

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [NCH-1:0]    stop = '0;
  logic [NCH*CW-1:0] count;
  logic [NCH-1:0]    ch_fin, ch_tmo;
  logic              done, no_win;
  logic [IW-1:0]     win;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  discharge_timer_bank #(.NUM_CH(NCH), .CNT_W(CW)) uut (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start),
    .stop_i    (stop),
    .count_o   (count),
    .ch_fin_o  (ch_fin),
    .ch_tmo_o  (ch_tmo),
    .done_o    (done),
    .win_idx_o (win),
    .no_win_o  (no_win)
  );

  function automatic int cnt_of(input int ch);
    return int'(count[ch*CW +: CW]);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_case(input int d[NCH], input int exp_win, input int exp_nowin,
                          input int re_ch, input int re_lo, input int re_hi,
                          input int mid_start);
    int exp_cnt[NCH];
    bit exp_to[NCH];
    int e_off = 0;
    int seen = -1;
    for (int ch = 0; ch < NCH; ch++) begin
      if (d[ch] >= 0 && d[ch] <= CMAX - 3) begin
        exp_cnt[ch] = d[ch] + 2;
        exp_to[ch]  = 1'b0;
        if (d[ch] + 3 > e_off) e_off = d[ch] + 3;
      end else begin
        exp_cnt[ch] = CMAX;
        exp_to[ch]  = 1'b1;
        if (CMAX > e_off) e_off = CMAX;
      end
    end
    @(negedge clk) start = 1'b1;
    @(posedge clk);
    @(negedge clk) start = 1'b0;
    check(done == 1'b0, "R2", "done cleared by start", int'(done), 0);
    check(cnt_of(0) == 0, "R2", "count zero after start", cnt_of(0), 0);
    check(no_win == 1'b0, "R2", "no_win cleared by start", int'(no_win), 0);
    for (int a = 0; a < CMAX + 12; a++) begin
      start = (a == mid_start);
      if (done && seen < 0) seen = a;
      if (seen >= 0 && a > re_hi + 4) break;
      for (int ch = 0; ch < NCH; ch++) begin
        if (d[ch] == a) stop[ch] = 1'b1;
        if (ch == re_ch && a == re_lo) stop[ch] = 1'b0;
        if (ch == re_ch && a == re_hi) stop[ch] = 1'b1;
      end
      @(posedge clk);
      @(negedge clk);
    end
    start = 1'b0;
    check(seen == e_off + 1, "R6", "done offset", seen, e_off + 1);
    for (int ch = 0; ch < NCH; ch++) begin
      check(cnt_of(ch) == exp_cnt[ch], exp_to[ch] ? "R5" : "R3", "channel count",
            cnt_of(ch), exp_cnt[ch]);
      check(ch_tmo[ch] == exp_to[ch], "R5", "timeout flag", int'(ch_tmo[ch]), int'(exp_to[ch]));
      check(ch_fin[ch] == 1'b1, "R6", "finished flag", int'(ch_fin[ch]), 1);
    end
    check(int'(win) == exp_win, "R7", "winner index", int'(win), exp_win);
    check(int'(no_win) == exp_nowin, "R8", "no-winner flag", int'(no_win), exp_nowin);
    stop = '0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int d[NCH];
    int held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(count == '0, "R1", "counts after reset", int'(count[CW-1:0]), 0);
    check(ch_fin == '0 && ch_tmo == '0, "R1", "flags after reset", int'(ch_fin), 0);
    check(done == 1'b0 && no_win == 1'b0 && win == '0, "R1", "bank outputs after reset",
          int'(done), 0);

    // R4: stop edge while idle is ignored
    stop[4] = 1'b1;
    repeat (5) @(negedge clk);
    check(ch_fin == '0 && cnt_of(4) == 0, "R4", "idle stop ignored", int'(ch_fin), 0);
    stop[4] = 1'b0;
    repeat (4) @(negedge clk);

    // table of vectors (R3 R5 R6 R7)
    for (int v = 0; v < NVEC; v++) begin
      for (int ch = 0; ch < NCH; ch++) d[ch] = VEC_DLY[v][ch];
      run_case(d, VEC_WIN[v], VEC_NOWIN[v], -1, -1, -1, -1);
    end

    // R4: stop edge while done is ignored, counts held
    held = cnt_of(7);
    stop[7] = 1'b1;
    repeat (6) @(negedge clk);
    check(cnt_of(7) == held && done == 1'b1, "R4", "stop while done ignored", cnt_of(7), held);
    stop[7] = 1'b0;
    repeat (4) @(negedge clk);

    // R8: every channel times out
    for (int ch = 0; ch < NCH; ch++) d[ch] = -1;
    run_case(d, 0, 1, -1, -1, -1, -1);

    // R4 second edge ignored, R2 start during run ignored
    for (int ch = 0; ch < NCH; ch++) d[ch] = 50;
    d[2] = 10;
    run_case(d, 2, 0, 2, 14, 20, 5);

    // R7 tie at minimum between channels 3 and 14, plus channel 0 timing out
    for (int ch = 0; ch < NCH; ch++) d[ch] = 40;
    d[0]  = -1;
    d[3]  = 0;
    d[14] = 0;
    run_case(d, 3, 0, -1, -1, -1, -1);

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      failures++;
      $display("FAIL R6 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule